// File: doc/BRIEF.md
# Data Watchpoint Range Matcher

This block holds a small bank of data watchpoint slots and compares every load or store the core issues against all of them at once. Each slot has a control word and a value word. Both are written through one indexed configuration port. The value word gives a doubleword-aligned base address. The control word chooses how the address is matched, which access kinds count, and at which privilege level.

A slot works in one of two modes. In byte-lane mode, it covers any subset of the eight bytes of one aligned doubleword. The access hits the slot if it touches any selected byte. In region mode, it ignores the low N address bits and so covers an aligned 2^N-byte region. Every slot is also filtered by access kind (load or store) and by privilege level. When several slots match, the lowest-numbered slot is reported. The hit flag, the slot number and the access address appear one clock after the access strobe. A debug or exception unit downstream acts on them.

Top module: `wpm_matcher`

## Requirements
- R1: After reset, `hit` is 0 and every control word is cleared, so no access hits any slot until a slot is programmed.
- R2: A write with `cfg_we`=1 updates slot `cfg_idx`. `cfg_sel`=0 selects the control word and `cfg_sel`=1 selects the value word. The value word's low three bits are stored as zero, so the compare is always on a doubleword base.
- R3: Byte-lane mode applies when control bits 28:24 are 0. The access touches 1, 2, 4 or 8 bytes (`acc_size` 0, 1, 2, 3), starting at lane `acc_addr[2:0]`, and lanes past byte 7 are dropped. The slot hits when `acc_addr` above bit 2 equals the value word above bit 2 and any touched lane is set in control bits 12:5 (bit 5 = byte 0).
- R4: Region mode applies when control bits 28:24 hold N with N ≥ 3. The slot hits when `acc_addr` and the value word agree above bit N-1. This mode also requires control bits 12:5 to be 0xFF; with any other value the slot never hits.
- R5: A mask count of 1 or 2 is reserved, and a slot programmed with either never hits.
- R6: Control bits 4:3 filter by access kind. 01 passes loads, 10 passes stores, 11 passes both, and 00 passes nothing.
- R7: Control bit 0 enables the slot. Control bit 1 passes unprivileged accesses (`acc_priv`=0) and control bit 2 passes privileged accesses (`acc_priv`=1).
- R8: A slot with control bit 20 set never hits. Control bits 19:13 are stored but do not affect matching.
- R9: When several slots hit, `hit_slot` reports the lowest-numbered one.
- R10: Results are registered. One cycle after an access with `acc_valid`=1:
  - `hit` shows the match result;
  - `hit_slot` shows the winning slot, or 0 on a miss;
  - `hit_addr` shows that access's address.

  `hit` is 0 in the cycle after a cycle without `acc_valid`. Accesses may arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = value word |
| cfg_idx | input | IW | Slot number for the write |
| cfg_wdata | input | AW | Write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | AW | Access address |
| acc_load | input | 1 | Access is a load |
| acc_store | input | 1 | Access is a store |
| acc_size | input | 2 | Access size code: 1, 2, 4 or 8 bytes |
| acc_priv | input | 1 | 1 = privileged access |
| hit | output | 1 | Registered watchpoint hit |
| hit_slot | output | IW | Winning slot number |
| hit_addr | output | AW | Captured access address |

## Verification
Byte-lane mode is tried with single bytes, halfwords and words that land on, beside, and straddling the selected lanes. This separates a correct lane computation from one that ignores the size or the offset. A word running past byte 7 and an access in the next doubleword confirm that dropped lanes and the upper-address compare stay separate. Region mode is tried at its first and last byte, one past each edge, and with a byte-select other than 0xFF. Reserved mask counts, each access-kind and privilege setting, the type bit and two overlapping slots separate the filters and the priority order. Back-to-back accesses show that each result lines up with its own access.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

  localparam int CTRL_W    = 32;
  localparam int B_EN      = 0;
  localparam int B_PRIV_LO = 1;
  localparam int B_LSC_LO  = 3;
  localparam int B_BAS_LO  = 5;
  localparam int B_TYPE    = 20;
  localparam int B_MCNT_LO = 24;
  localparam int MIN_MCNT  = 3;

  // byte lanes touched inside the aligned doubleword; lanes above 7 dropped
  function automatic logic [7:0] touched_lanes(input logic [2:0] off,
                                               input logic [1:0] size_code);
    logic [15:0] span;
    case (size_code)
      2'd0:    span = 16'h0001;
      2'd1:    span = 16'h0003;
      2'd2:    span = 16'h000F;
      default: span = 16'h00FF;
    endcase
    span = span << off;
    return span[7:0];
  endfunction

  function automatic logic kind_passes(input logic [1:0] lsc,
                                       input logic is_ld, input logic is_st);
    return (is_ld & lsc[0]) | (is_st & lsc[1]);
  endfunction

  function automatic logic level_passes(input logic [1:0] pf,
                                        input logic is_priv);
    return is_priv ? pf[1] : pf[0];
  endfunction

endpackage

// File: rtl/wpm_slot.sv
module wpm_slot
  import wpm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_val,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_load,
  input  logic          acc_store,
  input  logic [1:0]    acc_size,
  input  logic          acc_priv,
  output logic          match
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [AW-1:0]     base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= CTRL_W'(wdata);
      if (wr_val)  base_q <= {wdata[AW-1:3], 3'b000};
    end
  end

  logic       en_f, type_f;
  logic [1:0] pf_f, lsc_f;
  logic [7:0] bas_f;
  logic [4:0] mcnt_f;

  assign en_f   = ctrl_q[B_EN];
  assign pf_f   = ctrl_q[B_PRIV_LO +: 2];
  assign lsc_f  = ctrl_q[B_LSC_LO +: 2];
  assign bas_f  = ctrl_q[B_BAS_LO +: 8];
  assign type_f = ctrl_q[B_TYPE];
  assign mcnt_f = ctrl_q[B_MCNT_LO +: 5];

  // named events for the checks below
  logic mode_reserved, filt_ok, lane_hit, region_hit, addr_hit;
  logic [AW-1:0] diff;

  assign mode_reserved = (mcnt_f == 5'd1) || (mcnt_f == 5'd2);
  assign filt_ok       = kind_passes(lsc_f, acc_load, acc_store) &
                         level_passes(pf_f, acc_priv);
  assign diff          = acc_addr ^ base_q;
  assign lane_hit      = (diff[AW-1:3] == '0) &&
                         ((touched_lanes(acc_addr[2:0], acc_size) & bas_f) != 8'h00);
  assign region_hit    = (mcnt_f >= 5'(MIN_MCNT)) && (bas_f == 8'hFF) &&
                         ((diff >> mcnt_f) == '0);
  assign addr_hit      = (mcnt_f == 5'd0) ? lane_hit : region_hit;
  assign match         = en_f & ~type_f & filt_ok & addr_hit;

  p_reserved_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reserved |-> !match);
  p_linked_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
    type_f |-> !match);
  p_kind_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsc_f == 2'b00) |-> !match);
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_f |-> !match);

endmodule

// File: rtl/wpm_prio.sv
module wpm_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/wpm_matcher.sv
module wpm_matcher
  import wpm_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_load,
  input  logic          acc_store,
  input  logic [1:0]    acc_size,
  input  logic          acc_priv,
  output logic          hit,
  output logic [IW-1:0] hit_slot,
  output logic [AW-1:0] hit_addr
);

  logic [NSLOT-1:0] slot_match;
  logic             any_match;
  logic [IW-1:0]    win_idx;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wpm_slot #(.AW(AW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (cfg_we && !cfg_sel && (cfg_idx == IW'(g))),
      .wr_val    (cfg_we &&  cfg_sel && (cfg_idx == IW'(g))),
      .wdata     (cfg_wdata),
      .acc_addr  (acc_addr),
      .acc_load  (acc_load),
      .acc_store (acc_store),
      .acc_size  (acc_size),
      .acc_priv  (acc_priv),
      .match     (slot_match[g])
    );
  end

  wpm_prio #(.N(NSLOT), .IW(IW)) u_prio (
    .req (slot_match),
    .any (any_match),
    .idx (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_slot <= '0;
      hit_addr <= '0;
    end else if (acc_valid) begin
      hit      <= any_match;
      hit_slot <= any_match ? win_idx : '0;
      hit_addr <= acc_addr;
    end else begin
      hit      <= 1'b0;
    end
  end

  p_hit_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(acc_valid));
  p_addr_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid) |-> (hit_addr == $past(acc_addr)));
  p_winner_matched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((($past(slot_match) >> hit_slot) & NSLOT'(1)) != '0));
  p_no_lower_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (($past(slot_match) & ((NSLOT'(1) << hit_slot) - NSLOT'(1))) == '0));

endmodule

// File: tb/tb_wpm_matcher.sv
module tb_wpm_matcher;
  localparam int CLK_P = 10;
  localparam int NSLOT = 4;
  localparam int AW    = 32;
  localparam int IW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          acc_valid = 1'b0, acc_load = 1'b0, acc_store = 1'b0, acc_priv = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = '0;
  logic          hit;
  logic [IW-1:0] hit_slot;
  logic [AW-1:0] hit_addr;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  wpm_matcher #(.NSLOT(NSLOT), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_load(acc_load), .acc_store(acc_store),
    .acc_size(acc_size), .acc_priv(acc_priv), .hit(hit),
    .hit_slot(hit_slot), .hit_addr(hit_addr)
  );

  typedef struct {
    logic          h;
    logic [IW-1:0] s;
    logic [AW-1:0] a;
    string         tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [31:0] mk_ctrl(logic en, logic [1:0] pf, logic [1:0] lsc,
                                          logic [7:0] bas, logic [4:0] mcnt,
                                          logic typ, logic [6:0] other);
    return {3'b000, mcnt, 3'b000, typ, other, bas, lsc, pf, en};
  endfunction

  task automatic wr(input int idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives one access in the coming cycle and pushes its expected result
  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic ld,
                     input logic st, input logic pv, input logic eh,
                     input int es, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz;
    acc_load = ld; acc_store = st; acc_priv = pv;
    e.h = eh; e.s = eh ? IW'(es) : '0; e.a = a; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: compares one result per accepted access
  initial begin
    forever begin
      logic v;
      @(posedge clk);
      v = acc_valid && rst_n;
      #(CLK_P/4);
      if (v) begin
        exp_t e;
        n_chk++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R10 unexpected result hit=%0b slot=%0d", hit, hit_slot);
        end else begin
          e = sb.pop_front();
          if (hit !== e.h || hit_slot !== e.s || hit_addr !== e.a) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b slot=%0d addr=%h, exp hit=%0b slot=%0d addr=%h",
                     e.tag, hit, hit_slot, hit_addr, e.h, e.s, e.a);
          end
        end
      end else if (rst_n) begin
        n_chk++;
        if (hit !== 1'b0) begin
          n_fail++;
          $display("FAIL R10 hit after idle cycle: got %0b exp 0", hit);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: got hung exp finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (hit !== 1'b0 || hit_slot !== '0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got hit=%0b slot=%0d exp 0/0", hit, hit_slot);
    end
    acc(32'h0, 2'd3, 1, 1, 1, 0, 0, "R1 cleared slot at zero");
    acc(32'h100, 2'd3, 1, 0, 0, 0, 0, "R1 cleared slot");

    // slot 0: bytes 2,3 of doubleword 0x1000, base written with low bits set (R2)
    wr(0, 1'b1, 32'h0000_1007);
    wr(0, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'h0C, 5'd0, 0, 7'd0));
    acc(32'h1002, 2'd0, 1, 0, 0, 1, 0, "R2 R3 byte 2");
    acc(32'h1000, 2'd1, 1, 0, 0, 0, 0, "R3 bytes 0-1 miss");
    acc(32'h1001, 2'd1, 1, 0, 0, 1, 0, "R3 bytes 1-2 hit");
    acc(32'h1004, 2'd2, 1, 0, 0, 0, 0, "R3 upper word miss");
    acc(32'h1000, 2'd3, 1, 0, 0, 1, 0, "R3 full doubleword");
    acc(32'h1006, 2'd2, 1, 0, 0, 0, 0, "R3 lanes past 7 dropped");
    acc(32'h1008, 2'd0, 1, 0, 0, 0, 0, "R3 next doubleword");
    idle();

    // access kind (R6)
    wr(0, 1'b0, mk_ctrl(1, 2'b11, 2'b01, 8'h0C, 5'd0, 0, 7'd0));
    acc(32'h1002, 2'd0, 0, 1, 0, 0, 0, "R6 loads-only store");
    acc(32'h1002, 2'd0, 1, 0, 0, 1, 0, "R6 loads-only load");
    wr(0, 1'b0, mk_ctrl(1, 2'b11, 2'b10, 8'h0C, 5'd0, 0, 7'd0));
    acc(32'h1002, 2'd0, 1, 0, 0, 0, 0, "R6 stores-only load");
    acc(32'h1002, 2'd0, 0, 1, 0, 1, 0, "R6 stores-only store");
    wr(0, 1'b0, mk_ctrl(1, 2'b11, 2'b00, 8'h0C, 5'd0, 0, 7'd0));
    acc(32'h1002, 2'd0, 1, 1, 0, 0, 0, "R6 kind 00");

    // privilege and enable (R7)
    wr(0, 1'b0, mk_ctrl(1, 2'b01, 2'b11, 8'h0C, 5'd0, 0, 7'd0));
    acc(32'h1002, 2'd0, 1, 0, 1, 0, 0, "R7 unpriv-only priv");
    acc(32'h1002, 2'd0, 1, 0, 0, 1, 0, "R7 unpriv-only unpriv");
    wr(0, 1'b0, mk_ctrl(1, 2'b10, 2'b11, 8'h0C, 5'd0, 0, 7'd0));
    acc(32'h1002, 2'd0, 1, 0, 1, 1, 0, "R7 priv-only priv");
    acc(32'h1002, 2'd0, 1, 0, 0, 0, 0, "R7 priv-only unpriv");
    wr(0, 1'b0, mk_ctrl(0, 2'b11, 2'b11, 8'h0C, 5'd0, 0, 7'd0));
    acc(32'h1002, 2'd0, 1, 0, 0, 0, 0, "R7 disabled");

    // type bit and unused fields (R8)
    wr(0, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'h0C, 5'd0, 1, 7'd0));
    acc(32'h1002, 2'd0, 1, 0, 0, 0, 0, "R8 linked type");
    wr(0, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'h0C, 5'd0, 0, 7'h7F));
    acc(32'h1002, 2'd0, 1, 0, 0, 1, 0, "R8 bits 19:13 ignored");
    wr(0, 1'b0, 32'h0);

    // region mode on slot 1 (R4, R5)
    wr(1, 1'b1, 32'h0002_0000);
    wr(1, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'hFF, 5'd12, 0, 7'd0));
    acc(32'h0002_0000, 2'd0, 1, 0, 0, 1, 1, "R4 region first byte");
    acc(32'h0002_0FFF, 2'd0, 1, 0, 0, 1, 1, "R4 region last byte");
    acc(32'h0002_1000, 2'd0, 1, 0, 0, 0, 0, "R4 above region");
    acc(32'h0001_FFFF, 2'd0, 1, 0, 0, 0, 0, "R4 below region");
    wr(1, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'h7F, 5'd12, 0, 7'd0));
    acc(32'h0002_0000, 2'd0, 1, 0, 0, 0, 0, "R4 byte-select not FF");
    wr(1, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'hFF, 5'd2, 0, 7'd0));
    acc(32'h0002_0000, 2'd0, 1, 0, 0, 0, 0, "R5 mask 2");
    wr(1, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'hFF, 5'd1, 0, 7'd0));
    acc(32'h0002_0000, 2'd0, 1, 0, 0, 0, 0, "R5 mask 1");
    wr(1, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'hFF, 5'd3, 0, 7'd0));
    acc(32'h0002_0007, 2'd0, 1, 0, 0, 1, 1, "R4 mask 3 inside");
    acc(32'h0002_0008, 2'd0, 1, 0, 0, 0, 0, "R4 mask 3 outside");
    wr(1, 1'b0, 32'h0);

    // priority (R9)
    wr(2, 1'b1, 32'h0000_3000);
    wr(3, 1'b1, 32'h0000_3000);
    wr(2, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'h01, 5'd0, 0, 7'd0));
    wr(3, 1'b0, mk_ctrl(1, 2'b11, 2'b11, 8'h01, 5'd0, 0, 7'd0));
    acc(32'h3000, 2'd0, 0, 1, 1, 1, 2, "R9 lowest slot wins");
    acc(32'h3001, 2'd0, 0, 1, 1, 0, 0, "R9 neither lane");
    wr(2, 1'b0, 32'h0);
    acc(32'h3000, 2'd2, 1, 0, 0, 1, 3, "R9 next slot after disable");
    idle();
    idle();

    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R10 results missing: got %0d pending exp 0", sb.size());
    end
    summary();
  end
endmodule